// File: doc/BRIEF.md
# Serial DAC Input Loading Logic

This block is the digital front end of a 12-bit serial digital-to-analog converter. A host sends 16-bit words over a three-wire link made of a serial clock, a data line and an active-low frame strobe. Each word passes through a 16-bit input shift register. A separate 12-bit latch holds the value that sets the converter. A load strobe (active low) and a clear (active low) steer that latch. A mode input picks between a standalone link and a cascade link. In standalone mode a word counter blocks every clock edge after the sixteenth. In cascade mode the register passes bits on, without limit, to a serial output that feeds the next converter.

All link inputs are asynchronous to the system clock. Each one runs through a two-flop synchroniser, and falling-edge strobes are derived from the synchronised levels. When a frame opens, the level of the load strobe picks the update mode. A low level gives an automatic update on the sixteenth edge. A high level gives an update on a later falling edge of the load strobe. A format input picks how the latch is driven out: offset binary passes it unchanged, and two's complement inverts the top bit.

Top module: `serial_dac_loader`

## Requirements
- R1: A bit is taken from `sdin_i` into bit 0 of the shift register, and the older bits move one place up, on each falling edge of `sclk_i` while `sync_n_i` is low. Edges of `sclk_i` while `sync_n_i` is high change nothing.
- R2: The first bit sent is word bit 15. The latch always takes word bits 11..0, so the first four bits sent have no effect on the output.
- R3: With `chain_en_i` low, only the first 16 falling edges after `sync_n_i` falls reach the register. Any further edges in that frame are ignored.
- R4: If `ldac_n_i` is low when `sync_n_i` falls, the latch loads on the sixteenth falling edge of the frame.
- R5: If `ldac_n_i` is high when `sync_n_i` falls, the latch keeps its value through the whole transfer. It loads on the first falling edge of `ldac_n_i` that comes after the sixteenth shift.
- R6: With `chain_en_i` high, every edge in the frame shifts, and `sdo_o` shows bit 15 of the register. After two words have been sent, the first word comes out on `sdo_o` MSB first while the second word is held.
- R7: With `chain_en_i` low, `sdo_o` is held low.
- R8: A low on `clr_n_i` forces the latch to zero. This wins over a load that falls in the same cycle.
- R9: With `twos_fmt_i` high, `dac_code_o` is the latch with bit 11 inverted. With `twos_fmt_i` low, it is the latch unchanged.
- R10: After reset the latch is zero and `sdo_o` is low.
- R11: A new falling edge of `sync_n_i` cancels a strobed update that is still waiting. A later `ldac_n_i` fall therefore does not load, unless a full 16-edge transfer has come first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data in, MSB first |
| sync_n_i | input | 1 | Frame strobe, active low |
| ldac_n_i | input | 1 | Latch load strobe and update-mode select, active low |
| clr_n_i | input | 1 | Latch clear, active low |
| chain_en_i | input | 1 | 1 = cascade mode, 0 = standalone mode |
| twos_fmt_i | input | 1 | 1 = two's complement output coding |
| sdo_o | output | 1 | Serial data out in cascade mode |
| dac_code_o | output | 12 | Code driven to the converter |

## Verification
Counted from the clock edge that first samples a changed input, a shift lands on the third rising edge. An automatic load lands on the fourth. A strobed load and a clear land on the third. The format select acts on the output combinationally.

The bench holds every serial clock phase and strobe level for four system cycles. Before each comparison it waits at least six more cycles, and it samples on the falling clock edge, so every result is settled when read. In cascade mode the serial output is read just before each new serial clock edge. At that point it shows the bit that left on the previous edge.

// File: rtl/sdl_pkg.sv
// Package: shared constants and the output coding helper for the serial
// DAC loader. Assumes a word of WORD_W bits whose low DATA_W bits are data.
package sdl_pkg;
    // Positions of the link signals inside the synchroniser vector
    localparam int IDX_SCLK = 0;
    localparam int IDX_SYNC = 1;
    localparam int IDX_LDAC = 2;
    localparam int IDX_CLR  = 3;
    localparam int IDX_SDIN = 4;
    localparam int N_LINK   = 5;

    // Apply output coding: two's complement flips the top bit
    function automatic logic [11:0] apply_fmt(input logic [11:0] v, input logic twos);
        apply_fmt = twos ? {~v[11], v[10:0]} : v;
    endfunction
endpackage

// File: rtl/sdl_sync.sv
// Module: multi-bit level synchroniser. Each bit passes through STAGES
// flops into the system clock. Assumes the bits are independent levels.
module sdl_sync #(
    parameter int             WIDTH   = 5,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs along the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdl_fall.sv
// Module: falling-edge detector. Gives a one-cycle strobe per bit when a
// synchronised level goes from 1 to 0. Assumes its inputs are synchronous.
module sdl_fall #(
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/sdl_shifter.sv
// Module: input shift register with frame counter. In standalone mode it
// admits WORD_W shifts per frame. In cascade mode it shifts without limit.
// Pulses done_o on the WORD_W-th shift. Assumes single-cycle strobes in.
module sdl_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall_i,
    input  logic              sync_fall_i,
    input  logic              sync_lvl_i,
    input  logic              sdin_i,
    input  logic              chain_en_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              shift_en;

    // Gate: frame open, edge seen, and the counter not full unless cascading
    assign shift_en = sclk_fall_i && !sync_lvl_i && !sync_fall_i
                      && (chain_en_i || cnt_q != FULL);

    // Shift data, count edges (saturating), flag the last bit of a word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sync_fall_i) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                shreg_q <= {shreg_q[WORD_W-2:0], sdin_i};
                if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
                done_q <= (cnt_q == LAST);
            end
        end
    end

    assign shreg_o = shreg_q;
    assign done_o  = done_q;

    // R1
    frame_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lvl_i |=> $stable(shreg_q));
    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall_i && !sync_lvl_i && !sync_fall_i && cnt_q != FULL) |=> shreg_q[0] == $past(sdin_i));
    // R3
    gate_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en_i && cnt_q == FULL) |=> $stable(shreg_q));
endmodule

// File: rtl/sdl_latch.sv
// Module: DAC latch with update-mode capture. The mode is taken from the
// load level at frame start. Loads the low DATA_W bits automatically or on
// a load-strobe fall. Clear has top priority. Assumes single-cycle strobes.
module sdl_latch #(
    parameter int WORD_W = 16,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_fall_i,
    input  logic              ldac_lvl_i,
    input  logic              ldac_fall_i,
    input  logic              clr_lvl_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] shreg_i,
    output logic [DATA_W-1:0] latch_o
);
    logic [DATA_W-1:0] latch_q;
    logic              auto_q;
    logic              armed_q;
    logic              load_go;

    assign load_go = (done_i && auto_q) || (ldac_fall_i && armed_q);

    // Capture the update mode at frame start and track a pending strobe load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (sync_fall_i) begin
            auto_q  <= !ldac_lvl_i;
            armed_q <= 1'b0;
        end else if (done_i && !auto_q) begin
            armed_q <= 1'b1;
        end else if (ldac_fall_i && armed_q) begin
            armed_q <= 1'b0;
        end
    end

    // Update the latch: clear first, then any load
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (!clr_lvl_i) latch_q <= '0;
        else if (load_go)    latch_q <= shreg_i[DATA_W-1:0];
    end

    assign latch_o = latch_q;

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl_i |=> latch_q == '0);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvl_i && !load_go) |=> $stable(latch_q));
    // R4
    auto_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && auto_q && clr_lvl_i) |=> latch_q == $past(shreg_i[DATA_W-1:0]));
    // R11
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fall_i |=> !armed_q);
endmodule

// File: rtl/serial_dac_loader.sv
// Module: top of the serial DAC input loader. It synchronises the link,
// detects falling edges, shifts words in, updates the latch and applies the
// output coding. Assumes chain_en_i and twos_fmt_i are static settings.
module serial_dac_loader #(
    parameter int WORD_W = 16,
    parameter int DATA_W = 12,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              sync_n_i,
    input  logic              ldac_n_i,
    input  logic              clr_n_i,
    input  logic              chain_en_i,
    input  logic              twos_fmt_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] dac_code_o
);
    import sdl_pkg::*;

    logic [N_LINK-1:0] raw, lvl;
    logic [2:0]        fall;
    logic [WORD_W-1:0] shreg;
    logic              done;
    logic [DATA_W-1:0] latch;

    assign raw[IDX_SCLK] = sclk_i;
    assign raw[IDX_SYNC] = sync_n_i;
    assign raw[IDX_LDAC] = ldac_n_i;
    assign raw[IDX_CLR]  = clr_n_i;
    assign raw[IDX_SDIN] = sdin_i;

    sdl_sync #(.WIDTH(N_LINK), .STAGES(STAGES), .RST_VAL(5'b01111)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .lvl_o(lvl));

    sdl_fall #(.WIDTH(3), .RST_VAL(3'b111)) u_fall (
        .clk(clk), .rst_n(rst_n),
        .lvl_i({lvl[IDX_LDAC], lvl[IDX_SYNC], lvl[IDX_SCLK]}),
        .fall_o(fall));

    sdl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_fall_i(fall[0]), .sync_fall_i(fall[1]), .sync_lvl_i(lvl[IDX_SYNC]),
        .sdin_i(lvl[IDX_SDIN]), .chain_en_i(chain_en_i),
        .shreg_o(shreg), .done_o(done));

    sdl_latch #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .sync_fall_i(fall[1]), .ldac_lvl_i(lvl[IDX_LDAC]), .ldac_fall_i(fall[2]),
        .clr_lvl_i(lvl[IDX_CLR]), .done_i(done), .shreg_i(shreg), .latch_o(latch));

    // Serial output only in cascade mode
    assign sdo_o      = chain_en_i & shreg[WORD_W-1];
    assign dac_code_o = apply_fmt(latch, twos_fmt_i);

    // R7
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_i |-> !sdo_o);
endmodule

// File: tb/sim_serial_dac_loader.sv
module sim_serial_dac_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdin = 1'b0, sync_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic chain_en = 1'b0, twos_fmt = 1'b0;
    logic sdo;
    logic [11:0] code;
    int total = 0, bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    serial_dac_loader u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sync_n_i(sync_n),
        .ldac_n_i(ldac_n), .clr_n_i(clr_n), .chain_en_i(chain_en),
        .twos_fmt_i(twos_fmt), .sdo_o(sdo), .dac_code_o(code));

    // {twos_fmt, 16-bit word, expected 12-bit code}
    localparam logic [28:0] VEC [6] = '{
        {1'b0, 16'hF123, 12'h123},
        {1'b0, 16'h0ABC, 12'hABC},
        {1'b1, 16'h5FFF, 12'h7FF},
        {1'b1, 16'hA800, 12'h000},
        {1'b1, 16'h3000, 12'h800},
        {1'b0, 16'h0001, 12'h001}};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        @(negedge clk);
        sdin = b;
        sclk = 1'b0;
        wait_n(4);
        sclk = 1'b1;
        wait_n(4);
    endtask

    task automatic send_frame(input logic [15:0] w, input int extra);
        @(negedge clk); sync_n = 1'b0; wait_n(4);
        for (int i = 15; i >= 0; i--) pulse(w[i]);
        for (int i = 0; i < extra; i++) pulse(1'b1);
        sync_n = 1'b1; wait_n(6);
    endtask

    task automatic set_ldac(input logic v);
        @(negedge clk); ldac_n = v; wait_n(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // R10 reset state
        check("R10 code", 16'(code), 16'h000);
        check("R10 sdo", 16'(sdo), 16'h0);

        // R2 R4 R9: automatic update in standalone mode, vector table
        set_ldac(1'b0);
        for (int k = 0; k < 6; k++) begin
            twos_fmt = VEC[k][28];
            send_frame(VEC[k][27:12], 0);
            check("R4/R2/R9 vector", 16'(code), 16'(VEC[k][11:0]));
        end
        twos_fmt = 1'b0;

        // R5: strobed mode, latch holds through the transfer
        set_ldac(1'b1);
        send_frame(16'h9A5C, 0);
        check("R5 hold before strobe", 16'(code), 16'h001);
        check("R7 sdo low in standalone", 16'(sdo), 16'h0);
        // R1: edges with the frame closed are ignored
        for (int i = 0; i < 8; i++) pulse(1'b1);
        set_ldac(1'b0);
        check("R1/R5 strobe load", 16'(code), 16'hA5C);
        set_ldac(1'b1);

        // R3: extra edges beyond 16 are gated off
        send_frame(16'h0321, 8);
        set_ldac(1'b0);
        check("R3 gate", 16'(code), 16'h321);
        set_ldac(1'b1);

        // R11: a new frame cancels a waiting strobe load
        send_frame(16'h0456, 0);
        @(negedge clk); sync_n = 1'b0; wait_n(4);
        for (int i = 0; i < 4; i++) pulse(1'b1);
        sync_n = 1'b1; wait_n(6);
        set_ldac(1'b0);
        check("R11 cancel", 16'(code), 16'h321);
        set_ldac(1'b1);

        // R8: clear wins over a same-cycle strobe load
        send_frame(16'h07E7, 0);
        @(negedge clk); clr_n = 1'b0; ldac_n = 1'b0; wait_n(6);
        check("R8 clear priority", 16'(code), 16'h000);
        clr_n = 1'b1; ldac_n = 1'b1; wait_n(6);
        check("R8 stays clear", 16'(code), 16'h000);
        // R9: cleared latch in two's complement reads as mid code
        twos_fmt = 1'b1; wait_n(1);
        check("R9 clear in twos", 16'(code), 16'h800);
        twos_fmt = 1'b0;

        // R6: cascade mode, first word leaves on sdo while second enters
        chain_en = 1'b1;
        begin
            logic [15:0] w1, w2;
            w1 = 16'hC3A5; w2 = 16'h1B7E;
            @(negedge clk); sync_n = 1'b0; wait_n(4);
            for (int i = 15; i >= 0; i--) pulse(w1[i]);
            for (int i = 15; i >= 0; i--) begin
                check("R6 sdo bit", 16'(sdo), 16'(w1[i]));
                pulse(w2[i]);
            end
            sync_n = 1'b1; wait_n(6);
            set_ldac(1'b0);
            check("R6 cascade load", 16'(code), 16'hB7E);
            set_ldac(1'b1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule